// File: doc/BRIEF.md
# Data Lane Low-Power to High-Speed Mode Controller

This block sits on one receive data lane and decides, from the two single-ended low-power line levels, when the lane may leave low-power signalling and accept a high-speed burst. The raw line pair arrives asynchronously. It is brought into the reference clock domain by a two-flop synchroniser. A further filter accepts a new line state only once it has been seen on two consecutive synchronised samples.

A mode state machine moves through five states: stop, HS request, bridge, HS settle and HS receive. It watches for the one legal entry order. The lane must have rested in stop (both lines high) for a programmable minimum time. It then shows p-low/n-high, and then both lines low. Once that order is complete, the line termination is switched on. The high-speed receiver is then enabled while the leading run of HS zeros passes. After a programmable settle count, the downstream sync aligner is told that the lane carries live data. Any out-of-order line state during entry returns the lane to stop. Once in high-speed mode, only a return of both lines high ends the burst, and all three outputs then drop at once.

Both timing limits are inputs counted in reference clock cycles, so the integrating logic can set them from its own configuration.

Top module: `lp_hs_lane_ctrl`

## Requirements
- R1: While rst_n is low, and right after its release, term_en, hs_rx_en and hs_active are all 0.
- R2: A line state is written {lp_p_in, lp_n_in}: 11 is stop, 01 is request, 00 is bridge, 10 is an illegal entry step. A new raw state is recognised 4 clock edges after it is first sampled, and only if it was held for two consecutive cycles. A raw change lasting a single cycle is ignored.
- R3: The request state 01 is accepted only after the recognised state has been 11 for at least stop_min_cyc consecutive cycles. Otherwise the lane stays in stop and the stop dwell restarts.
- R4: After the ordered sequence 11, 01, 00, term_en rises. It is high in the 5th sampled cycle after the raw line pair changes to 00.
- R5: During entry, a 10 state, or a 00 state seen straight from stop, returns the lane to stop with term_en low.
- R6: hs_rx_en is high whenever hs_active is high and is never high without term_en. hs_active rises exactly settle_cyc+2 cycles after term_en rises, including when settle_cyc is 0.
- R7: While the lane is in bridge, settle or receive, the line states 00, 01 and 10 do not end the burst.
- R8: When 11 is recognised in high-speed mode, term_en, hs_rx_en and hs_active all fall in the same cycle, 4 cycles after the raw change.
- R9: If 11 is recognised in the last settle cycle, or in the cycle the settle count would expire, hs_active never rises. If it is recognised one cycle later, hs_active is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_p_in | input | 1 | Raw low-power level of the positive line |
| lp_n_in | input | 1 | Raw low-power level of the negative line |
| stop_min_cyc | input | CNT_W | Minimum stop dwell in cycles before entry is accepted |
| settle_cyc | input | CNT_W | Settle count of HS zeros before data is reported |
| term_en | output | 1 | Line termination enable |
| hs_rx_en | output | 1 | High-speed receiver enable |
| hs_active | output | 1 | Lane carries payload; enables the sync aligner |

## Verification
Two events can meet in one cycle: the settle counter reaching its limit, which promotes the lane to receive, and the filtered recognition of stop, which ends the burst. The bench times the raw return to 11 from the observed rise of term_en. It places the recognition in the last settle cycle, in the expiry cycle, and one cycle after. The exit must win in the first two cases, so hs_active never rises. In the third case hs_active may show a single-cycle pulse before it falls together with the other outputs.

// File: rtl/lp_hs_lane_ctrl.sv
module lp_hs_lane_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_p_in,
  input  logic             lp_n_in,
  input  logic [CNT_W-1:0] stop_min_cyc,
  input  logic [CNT_W-1:0] settle_cyc,
  output logic             term_en,
  output logic             hs_rx_en,
  output logic             hs_active
);

  localparam logic [1:0] LINE_STOP = 2'b11;
  localparam logic [1:0] LINE_REQ  = 2'b01;
  localparam logic [1:0] LINE_BRG  = 2'b00;
  localparam logic [CNT_W-1:0] TMR_MAX = {CNT_W{1'b1}};

  typedef enum logic [2:0] {
    M_STOP, M_REQ, M_BRIDGE, M_SETTLE, M_RECV
  } mode_t;

  logic [1:0] meta_q, sync_q, sync_d, line_q;
  mode_t      mode;
  logic [CNT_W-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 2'b00;
      sync_q <= 2'b00;
      sync_d <= 2'b00;
      line_q <= 2'b00;
    end else begin
      meta_q <= {lp_p_in, lp_n_in};
      sync_q <= meta_q;
      sync_d <= sync_q;
      if (sync_q == sync_d) line_q <= sync_q;
    end
  end

  wire at_stop = (line_q == LINE_STOP);
  wire armed   = (tmr >= stop_min_cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_STOP;
      tmr  <= '0;
    end else begin
      case (mode)
        M_STOP: begin
          if (at_stop) begin
            if (tmr != TMR_MAX) tmr <= tmr + 1'b1;
          end else if (line_q == LINE_REQ && armed) begin
            mode <= M_REQ;
            tmr  <= '0;
          end else begin
            tmr <= '0;
          end
        end
        M_REQ: begin
          if (line_q == LINE_BRG) begin
            mode <= M_BRIDGE;
          end else if (line_q != LINE_REQ) begin
            mode <= M_STOP;
            tmr  <= '0;
          end
        end
        M_BRIDGE: begin
          mode <= at_stop ? M_STOP : M_SETTLE;
          tmr  <= '0;
        end
        M_SETTLE: begin
          if (at_stop) begin
            mode <= M_STOP;
            tmr  <= '0;
          end else if (tmr >= settle_cyc) begin
            mode <= M_RECV;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        M_RECV: begin
          if (at_stop) begin
            mode <= M_STOP;
            tmr  <= '0;
          end
        end
        default: begin
          mode <= M_STOP;
          tmr  <= '0;
        end
      endcase
    end
  end

  wire in_hs  = (mode == M_BRIDGE) || (mode == M_SETTLE) || (mode == M_RECV);
  wire rx_on  = (mode == M_SETTLE) || (mode == M_RECV);

  assign term_en   = in_hs && !at_stop;
  assign hs_rx_en  = rx_on && !at_stop;
  assign hs_active = (mode == M_RECV) && !at_stop;

endmodule

// File: rtl/lp_hs_lane_chk.sv
module lp_hs_lane_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sync_q,
  input logic [1:0] sync_d,
  input logic [1:0] line_q,
  input logic       term_en,
  input logic       hs_rx_en,
  input logic       hs_active
);

  p_filter_two_samples_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_q) |-> (line_q == $past(sync_q)) && (line_q == $past(sync_d)));

  p_term_after_bridge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_en) |-> $past(line_q) == 2'b00);

  p_rx_needs_term_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rx_en |-> term_en);

  p_active_needs_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_active |-> hs_rx_en);

  p_active_after_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_active) |-> $past(hs_rx_en) && $past(term_en));

  p_stop_drops_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(term_en) && (line_q == 2'b11) |-> !hs_rx_en && !hs_active);

endmodule

bind lp_hs_lane_ctrl lp_hs_lane_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .sync_d(sync_d), .line_q(line_q),
  .term_en(term_en), .hs_rx_en(hs_rx_en), .hs_active(hs_active)
);

// File: tb/tb_lp_hs_lane_ctrl.sv
`timescale 1ns/1ps
module tb_lp_hs_lane_ctrl;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] lp = 2'b11;
  logic [CNT_W-1:0] stop_min_cyc = 16'd20;
  logic [CNT_W-1:0] settle_cyc = 16'd30;
  logic term_en, hs_rx_en, hs_active;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  lp_hs_lane_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .lp_p_in(lp[1]), .lp_n_in(lp[0]),
    .stop_min_cyc(stop_min_cyc), .settle_cyc(settle_cyc),
    .term_en(term_en), .hs_rx_en(hs_rx_en), .hs_active(hs_active)
  );

  // {line[1:0], hold[7:0], expected {term, rx, active}}
  localparam int NV = 25;
  localparam logic [12:0] VEC [NV] = '{
    {2'b11, 8'd40, 3'b000}, {2'b01, 8'd10, 3'b000}, {2'b00, 8'd10, 3'b110},
    {2'b00, 8'd40, 3'b111}, {2'b01, 8'd10, 3'b111}, {2'b10, 8'd10, 3'b111},
    {2'b11, 8'd10, 3'b000}, {2'b11, 8'd30, 3'b000}, {2'b10, 8'd10, 3'b000},
    {2'b00, 8'd10, 3'b000}, {2'b11, 8'd40, 3'b000}, {2'b00, 8'd10, 3'b000},
    {2'b01, 8'd10, 3'b000}, {2'b00, 8'd10, 3'b000}, {2'b11, 8'd40, 3'b000},
    {2'b01, 8'd10, 3'b000}, {2'b10, 8'd10, 3'b000}, {2'b00, 8'd10, 3'b000},
    {2'b11, 8'd5,  3'b000}, {2'b01, 8'd10, 3'b000}, {2'b00, 8'd10, 3'b000},
    {2'b11, 8'd40, 3'b000}, {2'b01, 8'd10, 3'b000}, {2'b00, 8'd40, 3'b111},
    {2'b11, 8'd10, 3'b000}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic hold(input logic [1:0] v, input int n);
    lp = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_and_time(output int t_term, output int t_act);
    t_term = 0;
    t_act = 0;
    lp = 2'b00;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (term_en && t_term == 0) t_term = i;
      if (hs_active && t_act == 0) begin
        t_act = i;
        break;
      end
    end
  endtask

  task automatic exit_and_time(output int t_drop, output logic others_low);
    t_drop = 0;
    others_low = 1'b0;
    lp = 2'b11;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (!term_en && t_drop == 0) begin
        t_drop = i;
        others_low = !hs_rx_en && !hs_active;
      end
    end
  endtask

  task automatic race_case(input int extra, input int exp_pulses, input string req);
    int act_cnt;
    hold(2'b11, 40);
    hold(2'b01, 10);
    lp = 2'b00;
    repeat (5) @(negedge clk);
    chk({req, " term_en up at 5"}, int'(term_en), 1);
    repeat (int'(settle_cyc) - 3 + extra) @(negedge clk);
    lp = 2'b11;
    act_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hs_active) act_cnt++;
    end
    chk({req, " hs_active cycles"}, act_cnt, exp_pulses);
    chk({req, " term_en after exit"}, int'(term_en), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int tt, ta, td;
    logic lo;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {term_en, hs_rx_en, hs_active}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", {term_en, hs_rx_en, hs_active}, 0);

    for (int k = 0; k < NV; k++) begin
      hold(VEC[k][12:11], int'(VEC[k][10:3]));
      // rows: 0-6 R4 R6 R7 R8, 8-17 R5, 18-20 R3, 21-24 R3 R4
      chk($sformatf("R3 R4 R5 R6 R7 R8 table row %0d", k),
          {term_en, hs_rx_en, hs_active}, int'(VEC[k][2:0]));
    end

    // R2: single-cycle 01 glitch must not arm the request
    hold(2'b11, 40);
    hold(2'b01, 1);
    hold(2'b11, 10);
    hold(2'b00, 15);
    chk("R2 one-cycle glitch ignored", {term_en, hs_rx_en, hs_active}, 0);

    // R4, R6 timing with settle 5, then R8 exit
    settle_cyc = 16'd5;
    hold(2'b11, 40);
    hold(2'b01, 10);
    enter_and_time(tt, ta);
    chk("R4 term_en latency", tt, 5);
    chk("R6 settle 5 active delay", ta - tt, 7);
    hold(2'b00, 5);
    exit_and_time(td, lo);
    chk("R8 exit latency", td, 4);
    chk("R8 all outputs fall together", int'(lo), 1);

    // R6 with zero settle
    settle_cyc = 16'd0;
    hold(2'b11, 40);
    hold(2'b01, 10);
    enter_and_time(tt, ta);
    chk("R6 settle 0 active delay", ta - tt, 2);
    exit_and_time(td, lo);

    // R9: exit against settle expiry
    settle_cyc = 16'd8;
    race_case(0, 0, "R9 exit in last settle cycle");
    race_case(1, 0, "R9 exit in expiry cycle");
    race_case(2, 1, "R9 exit one cycle later");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule